// File: doc/BRIEF.md
# Prescaled Down-Counting Event Timer

This block is a down counter whose steps come from one of two sources: a timer tick, made by dividing the system clock by an even, programmable ratio, or edges on one of two user input pins. The pins are resynchronised and then sampled only on the timer tick, and the edge that counts (rising, falling or both) is chosen in software. When a step finds the count at zero, the counter reloads from its reload register. It also raises a one-cycle interrupt and either toggles or pulses its output pin.

Software reaches four registers through a simple write/read bus:

| Address | Register |
|---------|----------|
| 0 | Control |
| 1 | Reload |
| 2 | Count |
| 3 | Prescale |

A control bit starts and stops the timer. While the timer is stopped, a write to the reload register also presets the count. A user-output option lets software drive the pin directly while the timer is idle.

Top module: `cnt_timer`

## Requirements
- R1: After a synchronous reset, every register reads 0, and `tmr_irq` and `tmr_out` are 0.
- R2: With source 0 (control bits [2:1] = 00) and run set (control bit 0), the count drops by one every 2*(P+1) system clocks, where P is the prescale register. The first step lands 2*(P+1) clocks after the edge that sets run.
- R3: A step taken while the count is 0 loads the reload value and raises `tmr_irq` for exactly one cycle, so a reload value R gives one interrupt every R+1 steps.
- R4: With control bit 5 at 0 (toggle mode), `tmr_out` inverts in the same cycle as each interrupt. After a stop it holds the parity of all interrupts since reset, provided control bit 6 is 0.
- R5: With control bit 5 at 1 (pulse mode) and the timer running, `tmr_out` equals `tmr_irq` in every cycle.
- R6: Source 1 counts edges of `user_in[0]`; source 2 counts edges of `user_in[1]`. The input that is not selected has no effect on the count.
- R7: Edge select (control bits [4:3]) works as follows: 00 counts rising edges only, 01 counts falling edges only, and 10 or 11 counts both. An input must hold each level for at least two timer ticks.
- R8: A write to the reload register while stopped also sets the count. The same write while running leaves the count unchanged.
- R9: While run is 0, the count holds its value.
- R10: With run 0 and control bit 6 (user-output enable) set, `tmr_out` is the inverse of control bit 7. With run 1 the pin follows its timer mode.
- R11: Reads return the register at `rd_addr` one cycle later, with unused upper bits read as 0. A write to the count register sets the count directly, and the prescale register keeps only its low PRE_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 reload, 2 count, 3 prescale) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | CNT_W | Registered read data |
| user_in | input | 2 | Asynchronous user event inputs |
| tmr_irq | output | 1 | One-cycle terminal-count interrupt |
| tmr_out | output | 1 | Timer output pin |

## Verification
The bench builds the block with an 8-bit count and a 4-bit prescaler. This lets it sweep every prescale value with two run lengths each and compare the frozen count against the arithmetic 2*(P+1) tick spacing. The small count width also keeps reload values of 0 to 5 cheap, so the terminal-count cadence, interrupt totals and toggle parity can be checked over many wraps. Edge-mode runs drive each input in turn while wiggling the other one, so the ignored input is observed at the count register.

// File: rtl/cnt_timer_pkg.sv
`timescale 1ns/1ps
package cnt_timer_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;
  localparam logic [ADDR_W-1:0] A_PRESC  = 2'd3;

  localparam int CTRL_W   = 8;
  localparam int CB_RUN   = 0;
  localparam int CB_PULSE = 5;
  localparam int CB_UEN   = 6;
  localparam int CB_UBIT  = 7;

  localparam int N_IN = 2;

  typedef enum logic [1:0] {
    SRC_TICK = 2'd0,
    SRC_IN0  = 2'd1,
    SRC_IN1  = 2'd2,
    SRC_TICK2 = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    EDG_RISE = 2'd0,
    EDG_FALL = 2'd1,
    EDG_BOTH = 2'd2,
    EDG_BOTH2 = 2'd3
  } edge_e;

  typedef struct packed {
    logic  ubit;
    logic  uen;
    logic  pulse;
    edge_e edg;
    src_e  src;
    logic  run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Even divider: one tick per 2*(div+1) clocks; held in its start state while stopped.
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] half_q;
  logic             phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      half_q  <= '0;
      phase_q <= 1'b0;
    end else if (half_q == div) begin
      half_q  <= '0;
      phase_q <= ~phase_q;
    end else begin
      half_q  <= half_q + 1'b1;
    end
  end

  assign tick = run && phase_q && (half_q == div);
endmodule

// File: rtl/tmr_insync.sv
`timescale 1ns/1ps
// Two-flop resync per input, then sampling on the timer tick; edges are
// reported for one full tick interval.
module tmr_insync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  for (genvar gi = 0; gi < N; gi++) begin : g_in
    logic meta_q, sync_q, samp_q, prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        samp_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= din[gi];
        sync_q <= meta_q;
        if (tick) begin
          samp_q <= sync_q;
          prev_q <= samp_q;
        end
      end
    end

    assign rise[gi] = samp_q & ~prev_q;
    assign fall[gi] = ~samp_q & prev_q;
  end
endmodule

// File: rtl/tmr_downcnt.sv
`timescale 1ns/1ps
module tmr_downcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             term
);
  logic at_zero;
  assign at_zero = (count == '0);
  // A software load on the same edge takes precedence and cancels the terminal event.
  assign term    = step && at_zero && !ld_en;

  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (ld_en) count <= ld_val;
    else if (step)  count <= at_zero ? reload : count - 1'b1;
  end
endmodule

// File: rtl/tmr_outstage.sv
`timescale 1ns/1ps
module tmr_outstage (
  input  logic clk,
  input  logic rst,
  input  logic term,
  input  logic run,
  input  logic pulse,
  input  logic uen,
  input  logic ubit,
  output logic irq,
  output logic pin
);
  logic tog_q, tog_n, pin_d;

  assign tog_n = tog_q ^ term;

  always_comb begin
    if (!run && uen) pin_d = ~ubit;
    else if (pulse)  pin_d = term;
    else             pin_d = tog_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q <= 1'b0;
      irq   <= 1'b0;
      pin   <= 1'b0;
    end else begin
      tog_q <= tog_n;
      irq   <= term;
      pin   <= pin_d;
    end
  end
endmodule

// File: rtl/cnt_timer.sv
`timescale 1ns/1ps
module cnt_timer
  import cnt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic [N_IN-1:0]   user_in,
  output logic              tmr_irq,
  output logic              tmr_out
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [PRE_W-1:0] presc_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] rd_nxt;
  logic             tick, step, term, ld_en;
  logic [N_IN-1:0]  rise, fall, hit;

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      presc_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_RELOAD: reload_q <= wr_data;
        A_PRESC:  presc_q  <= wr_data[PRE_W-1:0];
        default:  ;
      endcase
    end
  end

  assign ld_en = wr_en && ((wr_addr == A_COUNT) ||
                           (wr_addr == A_RELOAD && !ctrl_q.run));

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_q.run),
    .div  (presc_q),
    .tick (tick)
  );

  tmr_insync #(.N(N_IN)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .din  (user_in),
    .rise (rise),
    .fall (fall)
  );

  // step source and edge selection
  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      case (ctrl_q.edg)
        EDG_RISE: hit[i] = rise[i];
        EDG_FALL: hit[i] = fall[i];
        default:  hit[i] = rise[i] | fall[i];
      endcase
    end
    case (ctrl_q.src)
      SRC_IN0: step = tick && hit[0];
      SRC_IN1: step = tick && hit[1];
      default: step = tick;
    endcase
  end

  tmr_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .ld_en  (ld_en),
    .ld_val (wr_data),
    .reload (reload_q),
    .count  (count_q),
    .term   (term)
  );

  tmr_outstage u_out (
    .clk   (clk),
    .rst   (rst),
    .term  (term),
    .run   (ctrl_q.run),
    .pulse (ctrl_q.pulse),
    .uen   (ctrl_q.uen),
    .ubit  (ctrl_q.ubit),
    .irq   (tmr_irq),
    .pin   (tmr_out)
  );

  // registered read port
  always_comb begin
    rd_nxt = '0;
    case (rd_addr)
      A_CTRL:   rd_nxt[CTRL_W-1:0] = ctrl_q;
      A_RELOAD: rd_nxt = reload_q;
      A_COUNT:  rd_nxt = count_q;
      A_PRESC:  rd_nxt[PRE_W-1:0] = presc_q;
      default:  rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end
endmodule

// File: rtl/cnt_timer_chk.sv
`timescale 1ns/1ps
module cnt_timer_chk
  import cnt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [CTRL_W-1:0] ctrl,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  count,
  input logic              irq,
  input logic              pin
);
  logic [CNT_W-1:0] cnt_d1;
  logic [CNT_W-1:0] cnt_d1_m1;

  always_ff @(posedge clk) cnt_d1 <= count;
  assign cnt_d1_m1 = cnt_d1 - 1'b1;

  p_irq_single_r3: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (count == $past(reload)));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl[CB_RUN]) && !$past(wr_en) && !irq) |->
      (count == cnt_d1 || count == cnt_d1_m1));

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(ctrl[CB_RUN]) && !$past(wr_en)) |-> (count == cnt_d1));

  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl[CB_RUN] && ctrl[CB_PULSE]) |-> (pin == irq));

  p_user_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!ctrl[CB_RUN] && ctrl[CB_UEN]) |-> (pin == !$past(ctrl[CB_UBIT])));

  p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(ctrl[CB_RUN] && !ctrl[CB_PULSE]) && ($past(ctrl, 2) == $past(ctrl)))
      |-> (pin != $past(pin)));
endmodule

bind cnt_timer cnt_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .ctrl   (ctrl_q),
  .reload (reload_q),
  .count  (count_q),
  .irq    (tmr_irq),
  .pin    (tmr_out)
);

// File: tb/test_cnt_timer.sv
`timescale 1ns/1ps
module test_cnt_timer;
  import cnt_timer_pkg::*;

  localparam int CW = 8;
  localparam int PW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [CW-1:0]     wr_data = '0;
  logic [CW-1:0]     rd_data;
  logic [1:0]        user_in = '0;
  logic              tmr_irq, tmr_out;

  int  n_chk = 0, n_fail = 0;
  int  irq_total = 0, irq_b2b = 0, pulse_err = 0;
  bit  pchk = 0, done = 0, irq_d = 0;

  always #2.5 clk = ~clk;

  cnt_timer #(.CNT_W(CW), .PRE_W(PW)) i_cnt_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .user_in(user_in),
    .tmr_irq(tmr_irq), .tmr_out(tmr_out)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (tmr_irq) irq_total++;
      if (tmr_irq && irq_d) irq_b2b++;
      irq_d = tmr_irq;
      if (pchk && (tmr_out !== tmr_irq)) pulse_err++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mk(bit run, int src, int edg, bit pulse, bit uen, bit ub);
    return {ub, uen, pulse, edg[1:0], src[1:0], run};
  endfunction

  // called at a negedge; write takes effect at the next posedge
  task automatic wr(input int a, input int d);
    wr_addr = a[ADDR_W-1:0];
    wr_data = d[CW-1:0];
    wr_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[ADDR_W-1:0];
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic ext_run(input int src, input int edg, input int n);
    int v;
    int drv = src - 1;
    int oth = 1 - drv;
    int exp_steps = (edg >= 2) ? 2 * n : n;
    wr(A_PRESC, 0);
    wr(A_RELOAD, 200);
    wr(A_CTRL, mk(1, src, edg, 0, 0, 0));
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      user_in[drv] = 1'b1;
      user_in[oth] = ~user_in[oth];
      repeat (8) @(negedge clk);
      user_in[drv] = 1'b0;
      user_in[oth] = ~user_in[oth];
      repeat (8) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_COUNT, v);
    check($sformatf("R6/R7 src%0d edge%0d n%0d", src, edg, n), v, 200 - exp_steps);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, v2, base, n, par;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      check($sformatf("R1 reg%0d", a), v, 0);
    end
    check("R1 irq", int'(tmr_irq), 0);
    check("R1 out", int'(tmr_out), 0);

    // R11 readback, masking and direct count write
    wr(A_CTRL, 8'h58);
    rd(A_CTRL, v);
    check("R11 ctrl", v, 8'h58);
    wr(A_CTRL, 0);
    wr(A_PRESC, 8'hFA);
    rd(A_PRESC, v);
    check("R11 prescale mask", v, 8'h0A);
    wr(A_COUNT, 77);
    rd(A_COUNT, v);
    check("R11 count write", v, 77);
    wr(A_RELOAD, 33);
    rd(A_RELOAD, v);
    check("R11 reload read", v, 33);

    // R2 prescaler sweep
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 2; k++) begin
        int g = (k == 0) ? 3 * (p + 1) : 5 * (p + 1) + p;
        wr(A_PRESC, p);
        wr(A_RELOAD, 200);
        wr(A_CTRL, mk(1, 0, 0, 0, 0, 0));
        repeat (g) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_COUNT, v);
        check($sformatf("R2 p%0d g%0d", p, g), v, 200 - (g + 1) / (2 * (p + 1)));
      end
    end

    // R9 freeze while stopped
    rd(A_COUNT, v);
    repeat (40) @(negedge clk);
    rd(A_COUNT, v2);
    check("R9 frozen count", v2, v);

    // R3 / R4 terminal count with toggle output
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 2; k++) begin
        int g = (k == 0) ? 7 : 20;
        wr(A_PRESC, 0);
        wr(A_RELOAD, r);
        settle();
        base = irq_total;
        wr(A_CTRL, mk(1, 0, 0, 0, 0, 0));
        repeat (g) @(negedge clk);
        wr(A_CTRL, 0);
        rd(A_COUNT, v);
        n = (g + 1) / 2;
        check($sformatf("R3 count r%0d g%0d", r, g), v, r - (n % (r + 1)));
        settle();
        check($sformatf("R3 irq r%0d g%0d", r, g), irq_total - base, n / (r + 1));
        check($sformatf("R4 pin parity r%0d", r), int'(tmr_out), irq_total % 2);
      end
    end

    // R5 pulse mode
    wr(A_PRESC, 1);
    wr(A_RELOAD, 2);
    settle();
    base = irq_total;
    wr(A_CTRL, mk(1, 0, 0, 1, 0, 0));
    pchk = 1;
    repeat (40) @(negedge clk);
    pchk = 0;
    wr(A_CTRL, 0);
    settle();
    check("R5 pulse mismatches", pulse_err, 0);
    check("R5 irq count", irq_total - base, 3);

    // R6 / R7 external inputs
    for (int e = 0; e < 3; e++) begin
      for (int n2 = 1; n2 <= 5; n2 += 2) ext_run(1, e, n2);
    end
    ext_run(2, 0, 4);
    ext_run(2, 2, 3);

    // R8 reload writes
    wr(A_RELOAD, 50);
    wr(A_CTRL, mk(1, 1, 0, 0, 0, 0));
    repeat (4) @(negedge clk);
    wr(A_RELOAD, 9);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_COUNT, v);
    check("R8 running reload write keeps count", v, 50);
    rd(A_RELOAD, v);
    check("R8 reload updated", v, 9);
    wr(A_RELOAD, 9);
    rd(A_COUNT, v);
    check("R8 stopped reload write sets count", v, 9);

    // R10 user output
    wr(A_CTRL, mk(0, 0, 0, 0, 1, 0));
    repeat (2) @(negedge clk);
    check("R10 user bit 0", int'(tmr_out), 1);
    wr(A_CTRL, mk(0, 0, 0, 0, 1, 1));
    repeat (2) @(negedge clk);
    check("R10 user bit 1", int'(tmr_out), 0);
    settle();
    par = irq_total % 2;
    wr(A_CTRL, mk(1, 1, 0, 0, 1, par[0]));
    repeat (3) @(negedge clk);
    check("R10 running ignores user bit", int'(tmr_out), par);
    wr(A_CTRL, 0);

    settle();
    check("R3 irq never two cycles", irq_b2b, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule